// File: doc/BRIEF.md
# Byte-Serial Multi-Precision Adder/Subtractor

This unit adds or subtracts two wide operands one byte per clock. The lowest byte comes first. A caller pulses `start` while the unit is idle, selects add or subtract with `sub_sel`, and gives the operand length in bytes on `byte_cnt`. It then streams operand byte pairs on `a_byte`/`b_byte`, each marked by `in_valid`. Every accepted pair yields one result byte on `out_byte`, marked by `out_valid`, in the next cycle. A single internal flag carries the carry or borrow from one byte to the next. The lowest byte is computed without that flag. Every higher byte uses it: add-with-carry for addition, subtract-with-borrow for subtraction. On subtraction the flag is a borrow, so 1 means the byte went below zero.

One cycle after the last result byte, `done` pulses, and `carry_out` then holds the flag left by the top byte. That flag is the unsigned carry of the whole sum, or the unsigned borrow of the whole difference.

The controller has four named states:

| State | Role |
|---|---|
| IDLE | Waiting for a start |
| LOW | Waiting for the lowest byte |
| HIGH | Waiting for each further byte |
| WRAP | One cycle after the last byte is accepted |

It has the following named transitions:

| Transition | From | To | When |
|---|---|---|---|
| launch | IDLE | LOW | A valid start arrives |
| single | LOW | WRAP | The lowest byte is also the last |
| climb | LOW | HIGH | The lowest byte is accepted and more bytes follow |
| finish | HIGH | WRAP | The last byte is accepted |
| retire | WRAP | IDLE | Always, after one cycle; `done` pulses on arrival in IDLE |

Top module: `mp_serial_addsub`

## Requirements
- R1: After synchronous reset the unit is idle. `busy`, `out_valid`, `done` and `carry_out` are all 0.
- R2: A `start` in IDLE with a non-zero `byte_cnt` (1 to 2^CNT_W-1) latches the operation and the count, where `sub_sel`=1 means subtract. `busy` is 1 from the next cycle.
- R3: Each pair accepted while busy (`in_valid`=1 in LOW or HIGH) yields exactly one `out_valid` cycle in the following clock, in arrival order, lowest byte first.
- R4: The lowest byte is a plain a+b or a-b. The flag left over from an earlier operation has no effect on it.
- R5: For addition, each higher byte is a+b+flag. The new flag is 1 when that sum exceeds 0xFF.
- R6: For subtraction, each higher byte is a-b-flag. The new flag is 1 when a < b+flag, meaning a borrow occurred.
- R7: After `byte_cnt` pairs have been accepted, `done` is 1 for one cycle. That cycle is the cycle after the last `out_valid`, and `busy` is already 0 in it. `done` and `out_valid` are never 1 together.
- R8: After `done`, `carry_out` holds the flag from the top byte: the carry out of the whole sum, or 1 when the whole minuend is below the subtrahend. It keeps that value until the lowest byte of the next operation is accepted.
- R9: A `start` received while busy has no effect on the running operation's results, length or final flag.
- R10: A `start` with `byte_cnt`=0 is ignored, and the unit stays idle.
- R11: `in_valid` while idle produces no `out_valid` and does not change `carry_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (honoured only in IDLE) |
| sub_sel | input | 1 | 1 = subtract, 0 = add; sampled with start |
| byte_cnt | input | CNT_W | Operand length in bytes; sampled with start |
| in_valid | input | 1 | Operand byte pair present |
| a_byte | input | BYTE_W | Byte of the first operand (minuend) |
| b_byte | input | BYTE_W | Byte of the second operand (subtrahend) |
| out_valid | output | 1 | Result byte present |
| out_byte | output | BYTE_W | Result byte |
| done | output | 1 | One-cycle pulse after the last result byte |
| carry_out | output | 1 | Carry/borrow flag; final for the operation after done |
| busy | output | 1 | Unit is not in IDLE |

## Verification
A byte can be accepted in the same cycle as a fresh `start` pulse. The bench provokes this by raising `start` with the opposite operation and a length of one while the second byte of a longer operation is being fed. The scoreboard then judges the case. Every remaining result byte, the timing of `done` and the final `carry_out` must match the values computed for the original operation. An accepted restart would corrupt them.

// File: rtl/mp_serial_addsub_pkg.sv
package mp_serial_addsub_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_WRAP = 2'd3
    } seq_state_t;
endpackage

// File: rtl/byte_alu.sv
module byte_alu #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] opa,
    input  logic [BYTE_W-1:0] opb,
    input  logic              do_sub,
    input  logic              chain_en,
    input  logic              flag_in,
    output logic [BYTE_W-1:0] sum,
    output logic              flag_out
);
    logic              chained;
    logic              cin;
    logic [BYTE_W-1:0] opb_eff;
    logic [BYTE_W:0]   wide;

    always_comb begin
        chained  = chain_en & flag_in;
        // subtraction adds the inverted operand; borrow is the inverse of carry
        cin      = do_sub ? ~chained : chained;
        opb_eff  = do_sub ? ~opb : opb;
        wide     = {1'b0, opa} + {1'b0, opb_eff} + {{BYTE_W{1'b0}}, cin};
        sum      = wide[BYTE_W-1:0];
        flag_out = do_sub ? ~wide[BYTE_W] : wide[BYTE_W];
    end
endmodule

// File: rtl/byte_counter.sv
module byte_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (step)
            remain <= remain - ONE;
    end

    assign last = (remain == ONE);
endmodule

// File: rtl/mp_serial_addsub.sv
module mp_serial_addsub
    import mp_serial_addsub_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              sub_sel,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] a_byte,
    input  logic [BYTE_W-1:0] b_byte,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              done,
    output logic              carry_out,
    output logic              busy
);
    seq_state_t        state, state_nx;
    logic              op_sub;
    logic              flag;
    logic              launch;
    logic              accept;
    logic              last_byte;
    logic [BYTE_W-1:0] alu_sum;
    logic              alu_flag;

    assign launch = start && (state == ST_IDLE) && (byte_cnt != '0);
    assign accept = in_valid && ((state == ST_LOW) || (state == ST_HIGH));

    byte_counter #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .load     (launch),
        .load_val (byte_cnt),
        .step     (accept),
        .last     (last_byte)
    );

    byte_alu #(.BYTE_W(BYTE_W)) u_alu (
        .opa      (a_byte),
        .opb      (b_byte),
        .do_sub   (op_sub),
        .chain_en (state == ST_HIGH),
        .flag_in  (flag),
        .sum      (alu_sum),
        .flag_out (alu_flag)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (launch) state_nx = ST_LOW;
            ST_LOW:  if (accept) state_nx = last_byte ? ST_WRAP : ST_HIGH;
            ST_HIGH: if (accept && last_byte) state_nx = ST_WRAP;
            ST_WRAP: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_sub    <= 1'b0;
            flag      <= 1'b0;
            out_valid <= 1'b0;
            out_byte  <= '0;
            done      <= 1'b0;
        end else begin
            out_valid <= accept;
            done      <= (state == ST_WRAP);
            if (launch)
                op_sub <= sub_sel;
            if (accept) begin
                out_byte <= alu_sum;
                flag     <= alu_flag;
            end
        end
    end

    assign carry_out = flag;
    assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/mp_serial_addsub_checker.sv
module mp_serial_addsub_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [CNT_W-1:0] byte_cnt,
    input logic             in_valid,
    input logic             out_valid,
    input logic             done,
    input logic             carry_out,
    input logic             busy
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!busy && !out_valid && !done && !carry_out));

    assert_out_after_in_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    assert_out_while_busy_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> busy);

    assert_done_after_out_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(out_valid));

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_done_out_excl_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, out_valid}));

    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(carry_out));

    assert_zero_count_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && byte_cnt == '0) |=> !busy);

    assert_idle_input_R11: assert property (@(posedge clk) disable iff (rst)
        (!busy && in_valid) |=> !out_valid);
endmodule

bind mp_serial_addsub mp_serial_addsub_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .byte_cnt  (byte_cnt),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .done      (done),
    .carry_out (carry_out),
    .busy      (busy)
);

// File: tb/mp_serial_addsub_test.sv
`timescale 1ns/1ps
module mp_serial_addsub_test;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              sub_sel = 1'b0;
    logic [CNT_W-1:0]  byte_cnt = '0;
    logic              in_valid = 1'b0;
    logic [BYTE_W-1:0] a_byte = '0;
    logic [BYTE_W-1:0] b_byte = '0;
    logic              out_valid;
    logic [BYTE_W-1:0] out_byte;
    logic              done;
    logic              carry_out;
    logic              busy;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    mp_serial_addsub #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .start(start), .sub_sel(sub_sel), .byte_cnt(byte_cnt),
        .in_valid(in_valid), .a_byte(a_byte), .b_byte(b_byte),
        .out_valid(out_valid), .out_byte(out_byte), .done(done),
        .carry_out(carry_out), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every result byte
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3/R11 unexpected out_valid", {56'd0, out_byte}, 64'd0);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(out_byte == e, t, {56'd0, out_byte}, {56'd0, e});
            end
        end
    end

    // driver: one full operation, expected values from wide arithmetic
    task automatic run_op(input bit sub, input int n, input logic [63:0] a, input logic [63:0] b,
                          input bit gaps, input bit poke, input string tag);
        logic [63:0] m;
        logic [71:0] full;
        logic        exp_c;
        m = (n >= 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 * n)) - 64'd1);
        full = sub ? ({8'd0, a & m} - {8'd0, b & m}) : ({8'd0, a & m} + {8'd0, b & m});
        exp_c = full[8 * n];
        @(negedge clk);
        start = 1'b1; sub_sel = sub; byte_cnt = CNT_W'(n);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", {63'd0, busy}, 64'd1);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            a_byte = a[8*i +: 8];
            b_byte = b[8*i +: 8];
            exp_q.push_back(full[8*i +: 8]);
            tag_q.push_back(tag);
            if (poke && i == 1) begin
                start = 1'b1; sub_sel = ~sub; byte_cnt = CNT_W'(1);
            end
            @(negedge clk);
            start = 1'b0;
            in_valid = 1'b0;
            if (gaps) @(negedge clk);
        end
        if (!gaps) @(negedge clk);
        chk(done == 1'b1, "R7 done one cycle after last byte", {63'd0, done}, 64'd1);
        chk(busy == 1'b0, "R7 idle with done", {63'd0, busy}, 64'd0);
        chk(carry_out == exp_c, {tag, " R8 final flag"}, {63'd0, carry_out}, {63'd0, exp_c});
        chk(exp_q.size() == 0, "R3 byte count", exp_q.size(), 64'd0);
        @(negedge clk);
        chk(done == 1'b0, "R7 done is one pulse", {63'd0, done}, 64'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic saved;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !out_valid && !done && !carry_out, "R1 reset state",
            {60'd0, busy, out_valid, done, carry_out}, 64'd0);

        // R6: 0080h - 0090h = FFF0h with borrow
        run_op(1'b1, 2, 64'h0080, 64'h0090, 1'b0, 1'b0, "R6 sub chained borrow");
        // R4: flag is 1 now; lowest byte must ignore it
        run_op(1'b0, 1, 64'h10, 64'h20, 1'b0, 1'b0, "R4 add ignores stale flag");
        // R5: 0080h + 0070h = 00F0h, no carry
        run_op(1'b0, 2, 64'h0080, 64'h0070, 1'b0, 1'b0, "R5 add no carry");
        // R5: 0080h + 0090h = 0110h
        run_op(1'b0, 2, 64'h0080, 64'h0090, 1'b0, 1'b0, "R5 add chained carry");
        // set flag to 1, then R4 for subtraction
        run_op(1'b0, 1, 64'hFF, 64'h01, 1'b0, 1'b0, "R5 single byte carry");
        run_op(1'b1, 1, 64'h50, 64'h20, 1'b0, 1'b0, "R4 sub ignores stale flag");
        // R5 wide, with gaps between pairs
        run_op(1'b0, 8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b1, 1'b0, "R5 eight byte ripple");
        // R6 wide, no borrow out
        run_op(1'b1, 4, 64'h1234_0000, 64'h0000_0001, 1'b0, 1'b0, "R6 borrow ripple");
        // R9: start poked while second byte is accepted
        run_op(1'b0, 3, 64'hC0_FF80, 64'h50_0190, 1'b0, 1'b1, "R9 start while busy add");
        run_op(1'b1, 3, 64'h01_0203, 64'h01_0204, 1'b1, 1'b1, "R9 start while busy sub");

        // R8 hold over idle cycles
        saved = carry_out;
        repeat (4) @(negedge clk);
        chk(carry_out == saved, "R8 flag held while idle", {63'd0, carry_out}, {63'd0, saved});

        // R10: zero count
        start = 1'b1; byte_cnt = '0; sub_sel = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0, "R10 zero count ignored", {63'd0, busy}, 64'd0);

        // R11: pairs while idle
        in_valid = 1'b1; a_byte = 8'hFF; b_byte = 8'hFF;
        repeat (2) @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R11 no output while idle", {63'd0, out_valid}, 64'd0);
        chk(carry_out == saved, "R11 flag untouched", {63'd0, carry_out}, {63'd0, saved});

        // R1: reset mid-operation
        start = 1'b1; byte_cnt = CNT_W'(3); sub_sel = 1'b0;
        @(negedge clk);
        start = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy && !carry_out, "R1 reset returns idle", {62'd0, busy, carry_out}, 64'd0);
        run_op(1'b0, 2, 64'h00FF, 64'h0001, 1'b0, 1'b0, "R5 after reset");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule